// File: doc/BRIEF.md
# Single-to-Half Float Converter

This block turns a 32-bit IEEE 754 single-precision word into a 16-bit half-precision word. The rounding direction is picked per sample by a 2-bit mode select that travels with the data word: nearest with ties to even, toward zero, toward positive infinity or toward negative infinity. A valid strobe marks each sample. The result and its valid strobe come out of one register stage, so a new sample can be accepted on every clock.

Internally the magnitude (the input with its top bit cleared) is sorted into one of six categories. These are the named states of the block: `CLS_NAN` (magnitude above the single infinity pattern), `CLS_INF` (magnitude equal to it), `CLS_OVF` (finite but too large for a half), `CLS_NORM` (gives a normal half), `CLS_SUB` (gives a half subnormal) and `CLS_UNF` (too small for even the smallest subnormal). Each sample's category is settled in the same cycle it arrives, so the only movement between categories is from one sample to the next. A `unique case` over the category picks the result. Normal and subnormal values share one rounding adder. A carry out of the mantissa moves into the exponent field. The input sign is always placed in bit 15.

Top module: `f2h_convert`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock, and `out_half` carries the result of the word and mode sampled with that strobe. Reset clears `out_valid` and `out_half` to 0.
- R2: Bit 15 of every result equals bit 31 of the input word, including for zeros, NaNs and infinities.
- R3: A magnitude above 0x7F800000 gives 0x7E00 in bits 14..0 in every mode. A magnitude equal to 0x7F800000 gives 0x7C00 in every mode.
- R4: The mode code is 00 nearest-even, 01 toward zero, 10 toward positive, 11 toward negative, and it is sampled in the same cycle as the word. Input 0x3F801001 gives 0x3C01, 0x3C00, 0x3C01 and 0x3C00 under modes 00, 01, 10 and 11.
- R5: A finite magnitude at or above 0x47800000 overflows. Mode 00 gives 0x7C00 and mode 01 gives 0x7BFF. Mode 10 gives 0x7C00 for positive inputs and 0x7BFF for negative ones. Mode 11 gives 0x7C00 for negative inputs and 0x7BFF for positive ones.
- R6: A magnitude in [0x38800000, 0x47800000) gives a normal half. Its exponent field is the single exponent minus 112 and its mantissa is input bits 22..13. Bit 12 is the guard and bits 11..0 make up the sticky. 65504 (0x477FE000) gives 0x7BFF in mode 00.
- R7: A magnitude in [0x33000000, 0x38800000) gives a subnormal. The significand with its hidden bit is shifted right by 126 minus the exponent. The bit just below the result is the guard, and every lower bit feeds the sticky. 2^-24 (0x33800000) gives 0x0001.
- R8: The rounding increment is added to the truncated value. In mode 00 it is guard AND (sticky OR result bit 0). Mode 01 adds nothing. In mode 10 it is (NOT sign) AND (guard OR sticky), and in mode 11 it is sign AND (guard OR sticky). So 2^-25 (0x33000000) gives 0x0000 in mode 00 and 0x0001 in mode 10.
- R9: A rounding carry moves into the exponent. 65520 (0x477FF000) gives 0x7C00 in mode 00 and 0x7BFF in mode 01, and 0x387FFFFF gives 0x0400 in mode 00.
- R10: A magnitude below 0x33000000 gives a signed zero. The exceptions are a nonzero positive input in mode 10 and a nonzero negative input in mode 11, which give 0x0001 with the sign.
- R11: While `in_valid` is low, `out_half` keeps its last value whatever the word and mode inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a sample on `in_word` and `in_mode` |
| in_word | input | 32 | Single-precision operand |
| in_mode | input | 2 | Rounding direction code (R4) |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_half | output | 16 | Half-precision result |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid`, and there are no other delays. The bench changes inputs on the falling edge. It reads `out_valid` and `out_half` on the next falling edge, half a period after the register has updated, so each vector uses exactly one cycle and back-to-back samples with different modes are checked in order. The idle cycles used for the hold checks are read the same way, one falling edge after the strobe drops.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

    localparam int SGL_W      = 32;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_MAN_W  = 23;
    localparam int HLF_W      = 16;
    localparam int HLF_EXP_W  = 5;
    localparam int HLF_MAN_W  = 10;

    localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int HLF_BIAS   = (1 << (HLF_EXP_W - 1)) - 1;
    localparam int SIG_W      = SGL_MAN_W + 1;
    localparam int MAG_W      = SGL_W - 1;
    localparam int RES_W      = HLF_W - 1;
    localparam int MAN_DROP   = SGL_MAN_W - HLF_MAN_W;
    localparam int SH_W       = $clog2(SIG_W + 1);

    localparam int EXP_REBIAS = SGL_BIAS - HLF_BIAS;
    localparam int NORM_MIN_E = EXP_REBIAS + 1;
    localparam int SUB_MIN_E  = NORM_MIN_E - HLF_MAN_W - 1;
    localparam int OVF_E      = SGL_BIAS + HLF_BIAS + 1;
    localparam int SUB_SH_OFS = MAN_DROP + EXP_REBIAS;

    localparam logic [MAG_W-1:0] SGL_INF_MAG  = MAG_W'({SGL_EXP_W{1'b1}}) << SGL_MAN_W;
    localparam logic [MAG_W-1:0] OVF_MAG      = MAG_W'(OVF_E) << SGL_MAN_W;
    localparam logic [MAG_W-1:0] NORM_MIN_MAG = MAG_W'(NORM_MIN_E) << SGL_MAN_W;
    localparam logic [MAG_W-1:0] SUB_MIN_MAG  = MAG_W'(SUB_MIN_E) << SGL_MAN_W;

    localparam logic [RES_W-1:0] HLF_INF  = {{HLF_EXP_W{1'b1}}, {HLF_MAN_W{1'b0}}};
    localparam logic [RES_W-1:0] HLF_QNAN = {{HLF_EXP_W{1'b1}}, 1'b1, {(HLF_MAN_W-1){1'b0}}};
    localparam logic [RES_W-1:0] HLF_MAXF = {{(HLF_EXP_W-1){1'b1}}, 1'b0, {HLF_MAN_W{1'b1}}};
    localparam logic [RES_W-1:0] HLF_TINY = RES_W'(1);

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_TO_ZERO   = 2'b01,
        RND_TO_POS    = 2'b10,
        RND_TO_NEG    = 2'b11
    } rnd_mode_e;

    typedef enum logic [2:0] {
        CLS_NAN  = 3'd0,
        CLS_INF  = 3'd1,
        CLS_OVF  = 3'd2,
        CLS_NORM = 3'd3,
        CLS_SUB  = 3'd4,
        CLS_UNF  = 3'd5
    } mag_cls_e;

endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
    import f2h_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    output mag_cls_e         cls
);

    always_comb begin
        if (mag > SGL_INF_MAG)
            cls = CLS_NAN;
        else if (mag == SGL_INF_MAG)
            cls = CLS_INF;
        else if (mag >= OVF_MAG)
            cls = CLS_OVF;
        else if (mag >= NORM_MIN_MAG)
            cls = CLS_NORM;
        else if (mag >= SUB_MIN_MAG)
            cls = CLS_SUB;
        else
            cls = CLS_UNF;
    end

endmodule

// File: rtl/f2h_extract.sv
module f2h_extract
    import f2h_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    input  mag_cls_e         cls,
    output logic [RES_W-1:0] trunc_val,
    output logic             guard_bit,
    output logic             sticky_bit
);

    logic [SGL_EXP_W-1:0] exp_f;
    logic [SGL_MAN_W-1:0] man_f;
    logic [SIG_W-1:0]     sig;
    logic [SH_W-1:0]      sub_sh;
    logic [SIG_W-1:0]     sub_mask;
    logic [SIG_W-1:0]     sub_val;
    logic [HLF_EXP_W-1:0] norm_exp;

    assign exp_f    = mag[MAG_W-1 -: SGL_EXP_W];
    assign man_f    = mag[SGL_MAN_W-1:0];
    assign sig      = {1'b1, man_f};
    assign norm_exp = HLF_EXP_W'(exp_f - SGL_EXP_W'(EXP_REBIAS));
    assign sub_sh   = SH_W'(SGL_EXP_W'(SUB_SH_OFS) - exp_f);
    assign sub_mask = (SIG_W'(1) << sub_sh) - SIG_W'(1);
    assign sub_val  = sig >> (sub_sh + SH_W'(1));

    always_comb begin
        if (cls == CLS_SUB) begin
            trunc_val  = RES_W'(sub_val);
            guard_bit  = sig[sub_sh];
            sticky_bit = |(sig & sub_mask);
        end else begin
            trunc_val  = {norm_exp, man_f[SGL_MAN_W-1 -: HLF_MAN_W]};
            guard_bit  = man_f[MAN_DROP-1];
            sticky_bit = |man_f[MAN_DROP-2:0];
        end
    end

    // R7: a subnormal truncated value never reaches the normal range
    always_comb begin
        if (cls == CLS_SUB) begin
            assert_sub_below_norm_R7: assert (trunc_val < (RES_W'(1) << HLF_MAN_W));
        end
    end

endmodule

// File: rtl/f2h_round.sv
module f2h_round
    import f2h_pkg::*;
(
    input  logic [RES_W-1:0] trunc_val,
    input  logic             guard_bit,
    input  logic             sticky_bit,
    input  logic             sign,
    input  rnd_mode_e        mode,
    output logic [RES_W-1:0] rounded
);

    logic inc;

    always_comb begin
        unique case (mode)
            RND_NEAR_EVEN: inc = guard_bit & (sticky_bit | trunc_val[0]);
            RND_TO_ZERO:   inc = 1'b0;
            RND_TO_POS:    inc = ~sign & (guard_bit | sticky_bit);
            RND_TO_NEG:    inc = sign & (guard_bit | sticky_bit);
            default:       inc = 1'b0;
        endcase
    end

    assign rounded = trunc_val + RES_W'(inc);

    // R8: truncation mode never moves the value
    always_comb begin
        if (mode == RND_TO_ZERO) begin
            assert_trunc_exact_R8: assert (rounded == trunc_val);
        end
    end

endmodule

// File: rtl/f2h_core.sv
module f2h_core
    import f2h_pkg::*;
(
    input  logic [SGL_W-1:0] word,
    input  logic [1:0]       mode_code,
    output logic [HLF_W-1:0] half
);

    logic             sign;
    logic [MAG_W-1:0] mag;
    mag_cls_e         cls;
    rnd_mode_e        mode;
    logic [RES_W-1:0] trunc_val;
    logic             guard_bit;
    logic             sticky_bit;
    logic [RES_W-1:0] rounded;
    logic [RES_W-1:0] res;

    assign sign = word[SGL_W-1];
    assign mag  = word[MAG_W-1:0];
    assign mode = rnd_mode_e'(mode_code);

    f2h_classify u_classify (
        .mag (mag),
        .cls (cls)
    );

    f2h_extract u_extract (
        .mag        (mag),
        .cls        (cls),
        .trunc_val  (trunc_val),
        .guard_bit  (guard_bit),
        .sticky_bit (sticky_bit)
    );

    f2h_round u_round (
        .trunc_val  (trunc_val),
        .guard_bit  (guard_bit),
        .sticky_bit (sticky_bit),
        .sign       (sign),
        .mode       (mode),
        .rounded    (rounded)
    );

    always_comb begin
        unique case (cls)
            CLS_NAN:  res = HLF_QNAN;
            CLS_INF:  res = HLF_INF;
            CLS_OVF: begin
                unique case (mode)
                    RND_NEAR_EVEN: res = HLF_INF;
                    RND_TO_ZERO:   res = HLF_MAXF;
                    RND_TO_POS:    res = sign ? HLF_MAXF : HLF_INF;
                    RND_TO_NEG:    res = sign ? HLF_INF : HLF_MAXF;
                    default:       res = HLF_INF;
                endcase
            end
            CLS_NORM: res = rounded;
            CLS_SUB:  res = rounded;
            CLS_UNF: begin
                if ((mag != '0) &&
                    (((mode == RND_TO_POS) && !sign) || ((mode == RND_TO_NEG) && sign)))
                    res = HLF_TINY;
                else
                    res = '0;
            end
            default:  res = '0;
        endcase
    end

    assign half = {sign, res};

    // R5 / R10: saturating categories stay at their extremes
    always_comb begin
        if (cls == CLS_OVF) begin
            assert_ovf_extreme_R5: assert ((res == HLF_INF) || (res == HLF_MAXF));
        end
        if (cls == CLS_UNF) begin
            assert_unf_tiny_R10: assert (res <= HLF_TINY);
        end
    end

endmodule

// File: rtl/f2h_convert.sv
module f2h_convert
    import f2h_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_word,
    input  logic [1:0]       in_mode,
    output logic             out_valid,
    output logic [15:0]      out_half
);

    logic [HLF_W-1:0] conv_half;

    f2h_core u_core (
        .word      (in_word),
        .mode_code (in_mode),
        .half      (conv_half)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_half <= '0;
        else if (in_valid)
            out_half <= conv_half;
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_sign_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_half[15] == $past(in_word[31])));

    assert_nan_canon_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_word[30:0] > SGL_INF_MAG)) |=> (out_half[14:0] == HLF_QNAN));

    assert_inf_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_word[30:0] == SGL_INF_MAG)) |=> (out_half[14:0] == HLF_INF));

    assert_ovf_rne_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mode == 2'b00) && (in_word[30:0] >= OVF_MAG)
         && (in_word[30:0] <= SGL_INF_MAG)) |=> (out_half[14:0] == HLF_INF));

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_half));

endmodule

// File: tb/f2h_convert_tb_top.sv
module f2h_convert_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [15:0] out_half;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    f2h_convert dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_half  (out_half)
    );

    function automatic logic [15:0] model_half(input logic [31:0] w, input logic [1:0] md);
        logic   s;
        int     e;
        int     ee;
        int     te;
        int     sh;
        longint sig;
        longint kept;
        longint rem;
        longint hp;
        longint enc;
        bit     up;
        s = w[31];
        e = int'(w[30:23]);
        if (e == 255)
            return (w[22:0] != 0) ? {s, 15'h7E00} : {s, 15'h7C00};
        ee  = (e == 0) ? 1 : e;
        sig = (e == 0) ? longint'(w[22:0]) : longint'({1'b1, w[22:0]});
        te  = ee - 127;
        if (te < -14) te = -14;
        sh  = (te - 10) - (ee - 150);
        if (sh >= 40) begin
            kept = 0;
            rem  = (sig != 0) ? 1 : 0;
            hp   = 2;
        end else begin
            kept = sig >> sh;
            rem  = sig & ((64'sd1 <<< sh) - 1);
            hp   = 64'sd1 <<< (sh - 1);
        end
        case (md)
            2'b00:   up = (rem > hp) || ((rem == hp) && kept[0]);
            2'b01:   up = 1'b0;
            2'b10:   up = !s && (rem != 0);
            default: up = s && (rem != 0);
        endcase
        enc = longint'(te + 14) * 1024 + kept + (up ? 1 : 0);
        if (enc >= 64'h7C00) begin
            case (md)
                2'b00:   enc = 64'h7C00;
                2'b01:   enc = 64'h7BFF;
                2'b10:   enc = s ? 64'h7BFF : 64'h7C00;
                default: enc = s ? 64'h7C00 : 64'h7BFF;
            endcase
        end
        return {s, enc[14:0]};
    endfunction

    function automatic string region_tag(input logic [31:0] w);
        if (w[30:23] == 8'hFF)        return "R3";
        if (w[30:0] >= 31'h47800000)  return "R5";
        if (w[30:0] >= 31'h38800000)  return "R6";
        if (w[30:0] >= 31'h33000000)  return "R7";
        return "R10";
    endfunction

    task automatic check16(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge with the result checked
    task automatic run_vec(input logic [31:0] w, input logic [1:0] md,
                           input logic [15:0] exp, input string tag);
        in_word  = w;
        in_mode  = md;
        in_valid = 1'b1;
        @(negedge clk);
        check16({tag, " strobe"}, {15'b0, out_valid}, 16'h0001);
        check16(tag, out_half, exp);
    endtask

    task automatic run_model(input logic [31:0] w, input logic [1:0] md);
        run_vec(w, md, model_half(w, md), region_tag(w));
    endtask

    function automatic logic [22:0] man_pick(input int k);
        case (k)
            0:  return 23'h000000;
            1:  return 23'h000001;
            2:  return 23'h001000;
            3:  return 23'h001001;
            4:  return 23'h002000;
            5:  return 23'h003000;
            6:  return 23'h000FFF;
            7:  return 23'h400000;
            8:  return 23'h7FE000;
            9:  return 23'h7FF000;
            10: return 23'h7FFFFF;
            default: return 23'h2AAAAA;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [15:0] last;
        repeat (3) @(negedge clk);
        // R1 reset state
        check16("R1 reset valid", {15'b0, out_valid}, 16'h0000);
        check16("R1 reset data", out_half, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        run_vec(32'h477FE000, 2'b00, 16'h7BFF, "R6 max finite");
        run_vec(32'h477FF000, 2'b00, 16'h7C00, "R9 round to inf");
        run_vec(32'h477FF000, 2'b01, 16'h7BFF, "R9 trunc no carry");
        run_vec(32'h33800000, 2'b00, 16'h0001, "R7 min subnormal");
        run_vec(32'h33000000, 2'b00, 16'h0000, "R8 tie to even zero");
        run_vec(32'h33000000, 2'b10, 16'h0001, "R8 round up");
        run_vec(32'h387FFFFF, 2'b00, 16'h0400, "R9 sub to normal");
        run_vec(32'h80000000, 2'b00, 16'h8000, "R2 negative zero");
        run_vec(32'h00000000, 2'b11, 16'h0000, "R10 positive zero");
        run_vec(32'hFFC00001, 2'b01, 16'hFE00, "R3 nan");
        run_vec(32'h7F800001, 2'b10, 16'h7E00, "R3 signalling nan");
        run_vec(32'h7F800000, 2'b01, 16'h7C00, "R3 inf");
        run_vec(32'hFF800000, 2'b10, 16'hFC00, "R3 negative inf");
        run_vec(32'h8DA24260, 2'b11, 16'h8001, "R10 neg tiny down");
        run_vec(32'h8DA24260, 2'b10, 16'h8000, "R10 neg tiny up");
        run_vec(32'h0DA24260, 2'b10, 16'h0001, "R10 pos tiny up");
        run_vec(32'hC7800000, 2'b10, 16'hFBFF, "R5 neg ovf up");
        run_vec(32'hC7800000, 2'b11, 16'hFC00, "R5 neg ovf down");
        run_vec(32'h47800000, 2'b11, 16'h7BFF, "R5 pos ovf down");
        run_vec(32'h3F801001, 2'b00, 16'h3C01, "R4 mode 00");
        run_vec(32'h3F801001, 2'b01, 16'h3C00, "R4 mode 01");
        run_vec(32'h3F801001, 2'b10, 16'h3C01, "R4 mode 10");
        run_vec(32'h3F801001, 2'b11, 16'h3C00, "R4 mode 11");

        // R11 hold while idle, R1 strobe drop
        last = out_half;
        in_valid = 1'b0;
        in_word  = 32'h7FC00000;
        in_mode  = 2'b01;
        @(negedge clk);
        check16("R1 strobe low", {15'b0, out_valid}, 16'h0000);
        check16("R11 hold", out_half, last);
        in_word  = 32'hC0000000;
        @(negedge clk);
        check16("R11 hold again", out_half, last);

        // sweep: every exponent, both signs, all modes, selected mantissas
        for (int md = 0; md < 4; md++)
            for (int sg = 0; sg < 2; sg++)
                for (int ex = 0; ex < 256; ex++)
                    for (int k = 0; k < 12; k++)
                        run_model({sg[0], ex[7:0], man_pick(k)}, md[1:0]);

        // pseudo-random words focused on the finite half range
        lfsr = 32'h1ACE5EED;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run_model({lfsr[31], 3'b011, lfsr[27:0]}, lfsr[5:4]);
        end

        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule